// File: doc/BRIEF.md
# External Bus Zone Cycle Sequencer

This block sits between a processor core and an external memory/peripheral bus that is split into several chip-select zones. The core presents one request at a time and holds it stable until the block pulses `done`. A request carries a zone number, an address, a read/write flag, a byte/word size flag and write data. The block turns it into external bus cycles. It drives the address, one select per zone, a read strobe, two byte write strobes and a bus-state code. On a read it samples the returned data and hands it back on `rdata` in the `done` cycle.

Each zone has its own configuration field. The field holds a fast-read enable, a late-write option, a narrow (8-bit) bus flag, a wait-clock count and a hold-clock count. A read to a fast zone takes a single clock and starts in the same clock the request is presented. Every other access runs as a basic cycle: one address phase, then a strobe phase stretched by the wait clocks, then the hold clocks. A word access to a narrow zone is split into two basic byte cycles. The block forces an idle clock between a write and a following fast read. It also keeps the select asserted when fast reads to one zone follow each other.

Top module: `ebz_sequencer`

## Requirements
- R1: Under reset, and while no request is pending, the block drives `bus_state` = 0 (idle) and holds every select, `bus_rd`, `bus_wr` and `done` low.
- R2: The configuration for zone z is `zone_cfg[8z+7:8z]`, with the following fields:
  - bit 7: fast-read enable
  - bit 6: late write
  - bit 5: narrow bus
  - bits 4:2: wait clocks
  - bits 1:0: hold clocks

  A read to a fast zone that needs no split completes in the clock the request appears. In that clock `bus_state` = 4, the zone's select and `bus_rd` are high, `bus_wr` = 00 and `done` = 1. The zone's wait and hold counts have no effect on this cycle.
- R3: Fast reads to the same zone on consecutive clocks keep that zone's select and `bus_rd` high in every one of those clocks.
- R4: When the clock after a completed write would start a fast read, one idle clock is inserted first (`bus_state` = 0, no select, no strobe). This applies whichever zone the write used.
- R5: A write issued in the clock after a fast read to the same zone depends on the zone's late-write bit:
  - Bit set: the write's first phase follows at once, so the select stays high.
  - Bit clear: one idle clock with the select low comes before the write.
- R6: A basic cycle runs in this order:
  - One first-phase clock (`bus_state` = 1): select high, no strobe.
  - W+1 second-phase clocks (`bus_state` = 2): strobe high.
  - H hold clocks (`bus_state` = 3): select high, strobes low.

  Here W and H are the zone's wait and hold counts. `done` is high only in the last clock of the access.
- R7: A basic read samples `bus_din` in its last strobe clock. It returns that value on `rdata` in the `done` cycle, including when hold clocks follow.
- R8: A word access to a narrow zone runs as two basic cycles, first at the request address and then at address+1, with no gap between them.
  - Write: the low data byte goes first and the high byte second, both on `bus_dout[7:0]` with `bus_wr` = 01.
  - Read: `rdata` = {second byte, first byte}.
  - `done` rises only at the end of the second cycle.
- R9: The byte lanes of a wide zone are used as follows:
  - A word access uses `bus_wr` = 11 and all 16 data bits.
  - A byte access at an even address uses `bus_wr` = 01 and the low lane.
  - A byte access at an odd address uses `bus_wr` = 10 and the high lane.
  - Byte write data is driven on both lanes.
  - Byte reads are zero-extended.
  - Byte accesses to a narrow zone use lane 0.
- R10: At most one select is high at any time, and `bus_rd` is never high together with any write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zone_cfg | input | 8*NZ | Per-zone configuration fields |
| req | input | 1 | Core request, held until done |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_zone | input | ZW | Target zone |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | Access completes this clock |
| rdata | output | 16 | Read data, valid with done on a read |
| bus_addr | output | AW | External address |
| bus_sel | output | NZ | Per-zone selects, active high |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 2 | Byte write strobes (bit 0 low lane) |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_state | output | 3 | 0 idle, 1 first phase, 2 second phase, 3 hold, 4 fast read |

## Verification
Any fault in the wait/hold counter or the phase register shows up at once as a `bus_state` code that is one clock too long or too short. The same fault moves `done` by a clock, so it is visible in the first access to that zone. A lost turnaround or late-write flag appears within one clock as a missing or extra idle code, or as a select that drops or stays high wrongly. A wrong split byte index or a wrong capture register gives a wrong address in the second byte cycle, or swapped bytes on `rdata` in that access's `done` cycle.

// File: rtl/ebz_pkg.sv
package ebz_pkg;
  localparam int WAIT_W = 3;
  localparam int HOLD_W = 2;
  localparam int DW     = 16;
  localparam int BW     = 8;
  localparam int CNT_W  = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  typedef struct packed {
    logic              fast;
    logic              late_wr;
    logic              narrow;
    logic [WAIT_W-1:0] waits;
    logic [HOLD_W-1:0] holds;
  } zcfg_t;

  localparam int CFG_W = $bits(zcfg_t);

  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_HOLD = 3'd3,
    BS_FAST = 3'd4
  } bstate_e;

  function automatic logic needs_split(input logic narrow, input logic word);
    return narrow & word;
  endfunction

  function automatic logic [1:0] lane_strobe(input logic narrow, input logic word,
                                             input logic a0);
    if (narrow)    return 2'b01;
    else if (word) return 2'b11;
    else           return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [DW-1:0] lane_wdata(input logic narrow, input logic word,
                                               input logic hi_byte,
                                               input logic [DW-1:0] wdata);
    if (narrow)    return {{(DW-BW){1'b0}}, hi_byte ? wdata[DW-1:BW] : wdata[BW-1:0]};
    else if (word) return wdata;
    else           return {wdata[BW-1:0], wdata[BW-1:0]};
  endfunction

  function automatic logic [BW-1:0] pick_rbyte(input logic narrow, input logic a0,
                                               input logic [DW-1:0] din);
    if (!narrow && a0) return din[DW-1:BW];
    else               return din[BW-1:0];
  endfunction

  function automatic logic [DW-1:0] read_word(input logic narrow, input logic word,
                                              input logic a0, input logic [DW-1:0] din);
    if (word && !narrow) return din;
    else                 return {{(DW-BW){1'b0}}, pick_rbyte(narrow, a0, din)};
  endfunction
endpackage

// File: rtl/ebz_cfg_sel.sv
module ebz_cfg_sel
  import ebz_pkg::*;
#(
  parameter int NZ = 4,
  parameter int ZW = 2
) (
  input  logic [NZ*CFG_W-1:0] cfg_flat,
  input  logic [ZW-1:0]       zone,
  output zcfg_t               cfg
);
  zcfg_t arr [NZ];

  for (genvar i = 0; i < NZ; i++) begin : g_unpack
    assign arr[i] = cfg_flat[i*CFG_W +: CFG_W];
  end

  assign cfg = arr[zone];
endmodule

// File: rtl/ebz_fsm.sv
module ebz_fsm
  import ebz_pkg::*;
#(
  parameter int ZW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              split,
  input  logic              fast_ok,
  input  logic [ZW-1:0]     zone,
  input  logic              late_wr,
  input  logic [WAIT_W-1:0] waits,
  input  logic [HOLD_W-1:0] holds,
  output bstate_e           st,
  output logic              sel_on,
  output logic              rd_on,
  output logic              wr_on,
  output logic              sample,
  output logic              done,
  output logic              hi_byte
);
  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_HOLD} fsm_e;

  fsm_e             fs;
  logic [CNT_W-1:0] cnt;
  logic             hi_q;
  logic             prev_wr_q;
  logic             prev_fast_q;
  logic [ZW-1:0]    prev_zone_q;

  // named internal events
  logic launch, gap, fast_go, basic_go;
  logic strobe_last, hold_last, acc_end, byte_end;

  always_comb begin
    launch      = (fs == S_IDLE) && req;
    gap         = launch && !hi_q &&
                  ((fast_ok && prev_wr_q) ||
                   (req_wr && prev_fast_q && (prev_zone_q == zone) && !late_wr));
    fast_go     = launch && !gap && fast_ok && !hi_q;
    basic_go    = launch && !gap && !fast_go;
    strobe_last = (fs == S_STROBE) && (cnt == '0);
    hold_last   = (fs == S_HOLD) && (cnt == CNT_W'(1));
    acc_end     = (strobe_last && (holds == '0)) || hold_last;
    byte_end    = acc_end && split && !hi_q;
    done        = fast_go || (acc_end && !byte_end);
    sel_on      = fast_go || basic_go || (fs != S_IDLE);
    rd_on       = fast_go || ((fs == S_STROBE) && !req_wr);
    wr_on       = (fs == S_STROBE) && req_wr;
    sample      = fast_go || (strobe_last && !req_wr);
    hi_byte     = hi_q;
    case (fs)
      S_STROBE: st = BS_T2;
      S_HOLD:   st = BS_HOLD;
      default:  st = fast_go ? BS_FAST : (basic_go ? BS_T1 : BS_IDLE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs          <= S_IDLE;
      cnt         <= '0;
      hi_q        <= 1'b0;
      prev_wr_q   <= 1'b0;
      prev_fast_q <= 1'b0;
      prev_zone_q <= '0;
    end else begin
      prev_wr_q   <= done && req_wr;
      prev_fast_q <= fast_go;
      prev_zone_q <= zone;
      if (byte_end)  hi_q <= 1'b1;
      else if (done) hi_q <= 1'b0;
      case (fs)
        S_IDLE: if (basic_go) begin
          fs  <= S_STROBE;
          cnt <= CNT_W'(waits);
        end
        S_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (holds == '0) begin
            fs <= S_IDLE;
          end else begin
            fs  <= S_HOLD;
            cnt <= CNT_W'(holds);
          end
        end
        S_HOLD: begin
          if (cnt == CNT_W'(1)) fs <= S_IDLE;
          else                  cnt <= cnt - CNT_W'(1);
        end
        default: fs <= S_IDLE;
      endcase
    end
  end

  // R6: each extra second-phase clock consumes exactly one wait count
  a_r6_wait_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fs == S_STROBE && $past(fs) == S_STROBE) |-> (cnt == $past(cnt) - CNT_W'(1)));

  // R4: a completed write is never followed directly by a fast read
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_wr) |=> (st != BS_FAST));

  // R2: a fast read leaves no pending phase behind it
  a_r2_fast_single: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_FAST) |=> (fs == S_IDLE));

  // R8: the second byte of a split access starts with a first phase at once
  a_r8_split_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> (st == BS_T1));
endmodule

// File: rtl/ebz_rdcap.sv
module ebz_rdcap
  import ebz_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          split,
  input  logic          hi_byte,
  input  logic          narrow,
  input  logic          word,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] data_q;
  logic [DW-1:0] live;

  always_comb begin
    if (split) live = {din[BW-1:0], data_q[BW-1:0]};
    else       live = read_word(narrow, word, a0, din);
    rdata = sample ? live : data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (sample) begin
      if (split && !hi_byte) data_q[BW-1:0] <= din[BW-1:0];
      else                   data_q         <= live;
    end
  end

  // R8: the first byte of a split read survives the second byte's sample
  a_r8_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && split && hi_byte) |=> (data_q[BW-1:0] == $past(data_q[BW-1:0])));
endmodule

// File: rtl/ebz_sequencer.sv
module ebz_sequencer
  import ebz_pkg::*;
#(
  parameter int NZ = 4,
  parameter int AW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NZ*CFG_W-1:0] zone_cfg,
  input  logic                req,
  input  logic                req_wr,
  input  logic                req_word,
  input  logic [ZW-1:0]       req_zone,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                done,
  output logic [DW-1:0]       rdata,
  output logic [AW-1:0]       bus_addr,
  output logic [NZ-1:0]       bus_sel,
  output logic                bus_rd,
  output logic [1:0]          bus_wr,
  output logic [DW-1:0]       bus_dout,
  input  logic [DW-1:0]       bus_din,
  output logic [2:0]          bus_state
);
  zcfg_t   cfg;
  bstate_e st;
  logic    split, fast_ok;
  logic    sel_on, rd_on, wr_on, sample, hi_byte;

  ebz_cfg_sel #(.NZ(NZ), .ZW(ZW)) u_cfg (
    .cfg_flat (zone_cfg),
    .zone     (req_zone),
    .cfg      (cfg)
  );

  assign split   = needs_split(cfg.narrow, req_word);
  assign fast_ok = cfg.fast && !req_wr && !split;

  ebz_fsm #(.ZW(ZW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .req_wr  (req_wr),
    .split   (split),
    .fast_ok (fast_ok),
    .zone    (req_zone),
    .late_wr (cfg.late_wr),
    .waits   (cfg.waits),
    .holds   (cfg.holds),
    .st      (st),
    .sel_on  (sel_on),
    .rd_on   (rd_on),
    .wr_on   (wr_on),
    .sample  (sample),
    .done    (done),
    .hi_byte (hi_byte)
  );

  ebz_rdcap u_rdcap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sample),
    .split   (split),
    .hi_byte (hi_byte),
    .narrow  (cfg.narrow),
    .word    (req_word),
    .a0      (req_addr[0]),
    .din     (bus_din),
    .rdata   (rdata)
  );

  assign bus_addr  = sel_on ? (req_addr + AW'(hi_byte)) : '0;
  assign bus_sel   = sel_on ? (NZ'(1) << req_zone) : '0;
  assign bus_rd    = rd_on;
  assign bus_wr    = wr_on ? lane_strobe(cfg.narrow, req_word, req_addr[0]) : 2'b00;
  assign bus_dout  = wr_on ? lane_wdata(cfg.narrow, req_word, hi_byte, req_wdata) : '0;
  assign bus_state = st;

  // R10: one select at a time
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel));

  // R10: read and write strobes never overlap
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (bus_wr != 2'b00)));

  // R6: hold clocks keep the select but drop every strobe
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == BS_HOLD) |-> (!bus_rd && bus_wr == 2'b00 && bus_sel != '0));
endmodule

// File: tb/ebz_sequencer_bench.sv
module ebz_sequencer_bench;
  localparam int NZ = 4;
  localparam int ZW = 2;
  localparam int AW = 16;
  localparam logic [NZ*8-1:0] CFG = {8'h8F, 8'h20, 8'h06, 8'hC9};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_wr = 1'b0, req_word = 1'b0;
  logic [ZW-1:0] req_zone = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          done;
  logic [15:0]   rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;
  logic [NZ-1:0] bus_sel;
  logic          bus_rd;
  logic [1:0]    bus_wr;
  logic [2:0]    bus_state;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, ~a[7:0]};
  endfunction

  assign bus_din = mem_word(bus_addr);

  ebz_sequencer #(.NZ(NZ), .AW(AW)) u_ebz_sequencer (
    .clk(clk), .rst_n(rst_n), .zone_cfg(CFG), .req(req), .req_wr(req_wr),
    .req_word(req_word), .req_zone(req_zone), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_state(bus_state)
  );

  typedef struct packed {
    logic [2:0]    st;
    logic [NZ-1:0] sel;
    logic          rd;
    logic [1:0]    wr;
    logic          ca;
    logic [AW-1:0] addr;
    logic          cd;
    logic [15:0]   dout;
    logic          dn;
    logic          cr;
    logic [15:0]   rdat;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    n_chk = 0, n_fail = 0;
  bit    m_prev_wr = 0, m_prev_fast = 0;
  int    m_prev_zone = 0;

  function automatic exp_t mk(input logic [2:0] st, input logic [NZ-1:0] sel,
      input logic rd, input logic [1:0] wr, input logic ca, input logic [AW-1:0] addr,
      input logic cd, input logic [15:0] dout, input logic dn, input logic cr,
      input logic [15:0] rdat);
    exp_t e;
    e = '{st, sel, rd, wr, ca, addr, cd, dout, dn, cr, rdat};
    return e;
  endfunction

  function automatic exp_t idle_rec();
    return mk(3'd0, '0, 1'b0, 2'b00, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
  endfunction

  // scoreboard monitor: one expected record per clock, compared mid-cycle
  always @(negedge clk) begin
    exp_t  e;
    string t;
    bit    ok;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tq.pop_front();
      n_chk++;
      ok = (bus_state == e.st) && (bus_sel == e.sel) && (bus_rd == e.rd) &&
           (bus_wr == e.wr) && (done == e.dn) &&
           (!e.ca || bus_addr == e.addr) && (!e.cd || bus_dout == e.dout) &&
           (!e.cr || rdata == e.rdat);
      if (!ok) begin
        n_fail++;
        $display("FAIL %s t=%0t actual st=%0d sel=%b rd=%b wr=%b addr=%h dout=%h done=%b rdata=%h expected st=%0d sel=%b rd=%b wr=%b addr=%h dout=%h done=%b rdata=%h",
          t, $time, bus_state, bus_sel, bus_rd, bus_wr, bus_addr, bus_dout, done, rdata,
          e.st, e.sel, e.rd, e.wr, e.addr, e.dout, e.dn, e.rdat);
      end
    end
  end

  task automatic push(input exp_t e, input string t);
    q.push_back(e);
    tq.push_back(t);
  endtask

  task automatic idle_cycles(input int n, input string t);
    req = 1'b0;
    for (int i = 0; i < n; i++) push(idle_rec(), t);
    m_prev_wr = 0;
    m_prev_fast = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: presents one request, pushes the expected per-clock trace
  task automatic access(input int z, input bit wr, input bit word,
                        input logic [AW-1:0] a, input logic [15:0] wd, input string t);
    logic [7:0]    c;
    bit            fast, late, narrow, split, fastok;
    int            waits, holds, n, nb;
    logic [NZ-1:0] sel;
    logic [1:0]    stb;
    logic [15:0]   er, dv;
    c      = CFG[z*8 +: 8];
    fast   = c[7];
    late   = c[6];
    narrow = c[5];
    waits  = int'(c[4:2]);
    holds  = int'(c[1:0]);
    split  = narrow && word;
    fastok = fast && !wr && !split;
    sel    = NZ'(1) << z;
    stb    = narrow ? 2'b01 : (word ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
    if (split)        er = {mem_word(a + AW'(1))[7:0], mem_word(a)[7:0]};
    else if (narrow)  er = {8'h00, mem_word(a)[7:0]};
    else if (word)    er = mem_word(a);
    else              er = {8'h00, a[0] ? mem_word(a)[15:8] : mem_word(a)[7:0]};
    req = 1'b1; req_wr = wr; req_word = word; req_zone = ZW'(z);
    req_addr = a; req_wdata = wd;
    n = 0;
    if ((fastok && m_prev_wr) ||
        (wr && m_prev_fast && m_prev_zone == z && !late)) begin
      push(idle_rec(), t);
      n++;
    end
    if (fastok) begin
      push(mk(3'd4, sel, 1'b1, 2'b00, 1'b1, a, 1'b0, '0, 1'b1, 1'b1, er), t);
      n++;
    end else begin
      nb = split ? 2 : 1;
      for (int b = 0; b < nb; b++) begin
        bit last;
        last = (b == nb - 1);
        if (split)       dv = {8'h00, (b == 1) ? wd[15:8] : wd[7:0]};
        else if (narrow) dv = {8'h00, wd[7:0]};
        else if (word)   dv = wd;
        else             dv = {wd[7:0], wd[7:0]};
        push(mk(3'd1, sel, 1'b0, 2'b00, 1'b1, a + AW'(b), 1'b0, '0, 1'b0, 1'b0, '0), t);
        n++;
        for (int k = 0; k <= waits; k++) begin
          bit dn;
          dn = last && (k == waits) && (holds == 0);
          push(mk(3'd2, sel, !wr, wr ? stb : 2'b00, 1'b1, a + AW'(b), wr, dv,
                  dn, dn && !wr, er), t);
          n++;
        end
        for (int h = 1; h <= holds; h++) begin
          bit dn;
          dn = last && (h == holds);
          push(mk(3'd3, sel, 1'b0, 2'b00, 1'b1, a + AW'(b), 1'b0, '0,
                  dn, dn && !wr, er), t);
          n++;
        end
      end
    end
    m_prev_wr   = wr;
    m_prev_fast = fastok;
    m_prev_zone = z;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL R1 watchdog: actual=still running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++; // R1 reset state
    if (bus_state != 3'd0 || bus_sel != '0 || bus_rd || bus_wr != 2'b00 || done) begin
      n_fail++;
      $display("FAIL R1 reset: actual st=%0d sel=%b rd=%b wr=%b done=%b expected all zero",
               bus_state, bus_sel, bus_rd, bus_wr, done);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    idle_cycles(2, "R1 idle");
    // R2 fast word read (zone 0 has waits and holds that must be ignored)
    access(0, 0, 1, 16'h0010, 16'h0, "R2 fast word read");
    // R3 back-to-back fast reads keep select; R9 odd/even byte lanes
    access(0, 0, 0, 16'h0023, 16'h0, "R3 R9 fast odd byte read");
    access(0, 0, 0, 16'h0024, 16'h0, "R3 R9 fast even byte read");
    // R5 late write set: write follows with select held; R6 basic phases
    access(0, 1, 1, 16'h0040, 16'hBEEF, "R5 R6 late write word");
    // R4 turnaround after write
    access(0, 0, 1, 16'h0044, 16'h0, "R4 fast read after write");
    // R5 late write clear: idle inserted
    access(3, 0, 0, 16'h0101, 16'h0, "R2 fast read zone3");
    access(3, 1, 0, 16'h0102, 16'h00A5, "R5 R9 write no late");
    // R6 R7 basic read with waits and holds
    access(1, 0, 1, 16'h0200, 16'h0, "R6 R7 basic word read");
    access(1, 1, 0, 16'h0301, 16'h1234, "R9 odd byte write");
    access(3, 0, 1, 16'h0120, 16'h0, "R4 fast read after other zone write");
    access(0, 0, 1, 16'h0130, 16'h0, "R3 fast read zone change");
    idle_cycles(2, "R1 idle between");
    // R8 split accesses on narrow zone
    access(2, 0, 1, 16'h0400, 16'h0, "R8 split read");
    access(2, 1, 1, 16'h0410, 16'hC3D2, "R8 split write");
    access(2, 0, 0, 16'h0415, 16'h0, "R9 narrow byte read");
    access(1, 1, 1, 16'h0500, 16'h5AA5, "R9 word write");
    access(1, 0, 0, 16'h0507, 16'h0, "R7 R9 basic odd byte read");
    idle_cycles(3, "R1 idle end");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule